// File: doc/BRIEF.md
# Dual-port RAM message queue controller

This block is the hardware half of a message queue that lives in a shared dual-port RAM. A hardware producer pushes multi-word messages into fixed-size slots of the RAM, one word per request, and then either commits the message or throws it away. A processor on the other RAM port is the consumer: it sees how many messages are waiting through a small register window, reads the head slot from the RAM address the window reports, and then tells the block to advance past that slot.

The RAM write address is built from a software-set base, the slot index the producer is filling, and the word position within that slot. Status flags report whether the queue holds anything and whether a new slot may be filled. One slot is always left free, so the indices alone tell full from empty. An interrupt tells software that the queue has gone from empty to holding a message.

The register window has four words picked by a 2-bit address. Word 0 holds the controls, word 1 the indices and flags, word 2 the base and word 3 the head slot address. Reads come back one cycle after the request.

Top module: `mq_dpram_ctrl`

## Requirements
- R1: After reset both indices and the word offset are zero, `prod_ack`, `ram_we` and `irq` are low, start and interrupt enable are off, and register 1 reads 0x200 (not-full set, not-empty clear).
- R2: Every RAM write goes to address {base[6:0], in index[3:0], word offset[2:0]}, where base is bits 6:0 of register 2 (read/write). A message may use all eight offsets 0 to 7.
- R3: A producer request that is taken is seen at a clock edge. `ram_we` is high for exactly the next cycle with `ram_wdata` equal to the request data. `prod_ack` rises one cycle later and stays high while `prod_req` stays high. It falls on the edge after `prod_req` drops, and the word offset then steps by one.
- R4: `prod_done` with the producer idle commits the message: the in index steps by one (mod 16) and the offset returns to 0. `prod_abort` returns the offset to 0 and leaves the in index unchanged, so the next message rewrites the same slot from offset 0.
- R5: Register 1 reads in index in bits 3:0, out index in bits 7:4, not-empty in bit 8 (set when the indices differ) and not-full in bit 9 (clear when in+1 equals out mod 16). At most 15 messages can be held.
- R6: While not-full is clear, a request gets no write and no ack, and done is not taken. A request still held is served once a pop frees a slot.
- R7: While the start bit (register 0 bit 0) is clear, requests get no write and no ack, and done does not commit.
- R8: Writing register 1 with bit 0 set pops: the out index steps by one when not-empty is set. The write is ignored when the queue is empty.
- R9: Register 3 reads the head slot address {base, out index, 3'b000} in bits 13:0.
- R10: Writing register 0 with bit 2 set clears both indices and the offset to zero. This bit always reads back as 0.
- R11: A commit into an empty queue sets the interrupt pending bit (register 0 bit 3 on read). `irq` is pending AND interrupt enable (register 0 bit 1). Writing register 0 with bit 3 set clears pending, unless the same cycle also sets it. A commit into a non-empty queue does not set it.
- R12: A read request on the register port returns its data on `reg_rdata` after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prod_req | input | 1 | Producer asks to store one word |
| prod_done | input | 1 | Producer commits the current message |
| prod_abort | input | 1 | Producer discards the current message |
| prod_data | input | 16 | Word to store |
| prod_ack | output | 1 | Word stored; held until request drops |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 14 | RAM write address |
| ram_wdata | output | 16 | RAM write data |
| reg_en | input | 1 | Register port access |
| reg_we | input | 1 | Register port write (else read) |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| irq | output | 1 | Queue-became-non-empty interrupt |

## Verification
Results arrive at fixed latencies. The write strobe, address and data appear in the cycle after the edge that takes a request, ack follows one cycle later, and ack drops on the edge after the request falls. The bench checks each of these at the falling edge of the cycle in which it is due. Index, flag and interrupt changes from a commit, abort, pop or clear land on the edge that takes the command. The bench checks them through a register read, whose data it samples one edge after the request. Cases that must not act (full, not started, empty pop) are held for several cycles. The bench counts RAM writes during that time and confirms that no ack appears.

// File: rtl/mq_pkg.sv
package mq_pkg;
   typedef enum logic [1:0] {PS_WAIT, PS_WRITE, PS_ACK} prod_state_t;

   localparam logic [1:0] REG_CTRL = 2'd0;
   localparam logic [1:0] REG_STAT = 2'd1;
   localparam logic [1:0] REG_BASE = 2'd2;
   localparam logic [1:0] REG_HEAD = 2'd3;

   localparam int CB_START = 0;
   localparam int CB_IE    = 1;
   localparam int CB_CLR   = 2;
   localparam int CB_ACK   = 3;
   localparam int SB_POP   = 0;
endpackage

// File: rtl/mq_regs.sv
module mq_regs
   import mq_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int SLOT_W   = 4,
   parameter int WORD_W   = 3,
   parameter int BASE_W   = 7,
   parameter bit READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_en,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [SLOT_W-1:0] in_idx,
   input  logic              pend_set,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              start,
   output logic              irq_en,
   output logic              irq_pend,
   output logic [BASE_W-1:0] base,
   output logic [SLOT_W-1:0] out_idx,
   output logic              not_full,
   output logic              clr_p
);
   localparam int ADDR_W = BASE_W + SLOT_W + WORD_W;

   logic              wr_ctrl, wr_stat, wr_base;
   logic              not_empty, pop;
   logic [DATA_W-1:0] rd_mux;

   assign wr_ctrl   = reg_en && reg_we && (reg_addr == REG_CTRL);
   assign wr_stat   = reg_en && reg_we && (reg_addr == REG_STAT);
   assign wr_base   = reg_en && reg_we && (reg_addr == REG_BASE);
   assign clr_p     = wr_ctrl && reg_wdata[CB_CLR];
   assign not_empty = (in_idx != out_idx);
   assign not_full  = (SLOT_W'(in_idx + 1'b1) != out_idx);
   assign pop       = wr_stat && reg_wdata[SB_POP] && not_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start    <= 1'b0;
         irq_en   <= 1'b0;
         irq_pend <= 1'b0;
         base     <= '0;
         out_idx  <= '0;
      end else begin
         if (wr_ctrl) begin
            start  <= reg_wdata[CB_START];
            irq_en <= reg_wdata[CB_IE];
         end
         if (wr_base)
            base <= reg_wdata[BASE_W-1:0];
         if (clr_p)
            out_idx <= '0;
         else if (pop)
            out_idx <= out_idx + 1'b1;
         if (pend_set)
            irq_pend <= 1'b1;
         else if (wr_ctrl && reg_wdata[CB_ACK])
            irq_pend <= 1'b0;
      end
   end

   always_comb begin
      rd_mux = '0;
      case (reg_addr)
         REG_CTRL: begin
            rd_mux[CB_START] = start;
            rd_mux[CB_IE]    = irq_en;
            rd_mux[CB_ACK]   = irq_pend;
         end
         REG_STAT: begin
            rd_mux[SLOT_W-1:0]        = in_idx;
            rd_mux[2*SLOT_W-1:SLOT_W] = out_idx;
            rd_mux[2*SLOT_W]          = not_empty;
            rd_mux[2*SLOT_W+1]        = not_full;
         end
         REG_BASE: rd_mux[BASE_W-1:0] = base;
         default:  rd_mux[ADDR_W-1:0] = {base, out_idx, {WORD_W{1'b0}}};
      endcase
   end

   generate
      if (READ_REG) begin : g_rd_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               reg_rdata <= '0;
            else if (reg_en && !reg_we)
               reg_rdata <= rd_mux;
         end
      end else begin : g_rd_comb
         assign reg_rdata = rd_mux;
      end
   endgenerate
endmodule

// File: rtl/mq_producer.sv
module mq_producer
   import mq_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int SLOT_W = 4,
   parameter int WORD_W = 3,
   parameter int BASE_W = 7
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              prod_req,
   input  logic                              prod_done,
   input  logic                              prod_abort,
   input  logic [DATA_W-1:0]                 prod_data,
   input  logic                              start,
   input  logic                              not_full,
   input  logic                              clr_p,
   input  logic [BASE_W-1:0]                 base,
   output logic                              prod_ack,
   output logic                              ram_we,
   output logic [BASE_W+SLOT_W+WORD_W-1:0]   ram_addr,
   output logic [DATA_W-1:0]                 ram_wdata,
   output logic [SLOT_W-1:0]                 in_idx,
   output logic                              commit
);
   prod_state_t       state;
   logic [WORD_W-1:0] offset;
   logic              open;
   logic              take_req;

   assign open     = start && not_full;
   assign commit   = (state == PS_WAIT) && !prod_abort && prod_done && open && !clr_p;
   assign take_req = (state == PS_WAIT) && !prod_abort && !prod_done && prod_req && open;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= PS_WAIT;
         offset    <= '0;
         in_idx    <= '0;
         prod_ack  <= 1'b0;
         ram_we    <= 1'b0;
         ram_addr  <= '0;
         ram_wdata <= '0;
      end else if (clr_p) begin
         state    <= PS_WAIT;
         offset   <= '0;
         in_idx   <= '0;
         prod_ack <= 1'b0;
         ram_we   <= 1'b0;
      end else begin
         unique case (state)
            PS_WAIT: begin
               if (prod_abort) begin
                  offset <= '0;
               end else if (commit) begin
                  in_idx <= in_idx + 1'b1;
                  offset <= '0;
               end else if (take_req) begin
                  ram_we    <= 1'b1;
                  ram_addr  <= {base, in_idx, offset};
                  ram_wdata <= prod_data;
                  state     <= PS_WRITE;
               end
            end
            PS_WRITE: begin
               ram_we   <= 1'b0;
               prod_ack <= 1'b1;
               state    <= PS_ACK;
            end
            PS_ACK: begin
               if (!prod_req) begin
                  prod_ack <= 1'b0;
                  offset   <= offset + 1'b1;
                  state    <= PS_WAIT;
               end
            end
            default: state <= PS_WAIT;
         endcase
      end
   end
endmodule

// File: rtl/mq_dpram_ctrl.sv
module mq_dpram_ctrl
   import mq_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int SLOT_W   = 4,
   parameter int WORD_W   = 3,
   parameter int BASE_W   = 7,
   parameter bit READ_REG = 1'b1,
   localparam int ADDR_W  = BASE_W + SLOT_W + WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prod_req,
   input  logic              prod_done,
   input  logic              prod_abort,
   input  logic [DATA_W-1:0] prod_data,
   output logic              prod_ack,
   output logic              ram_we,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   input  logic              reg_en,
   input  logic              reg_we,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq
);
   generate
      if (DATA_W < ADDR_W || DATA_W < 2*SLOT_W + 2 || DATA_W < 4)
         $error("mq_dpram_ctrl: DATA_W too narrow for register fields");
      if (SLOT_W < 2 || WORD_W < 1 || BASE_W < 1)
         $error("mq_dpram_ctrl: SLOT_W, WORD_W, BASE_W out of range");
   endgenerate

   logic [SLOT_W-1:0] in_idx, out_idx;
   logic [BASE_W-1:0] base;
   logic              start, irq_en, irq_pend, not_full, clr_p, commit, pend_set;

   assign pend_set = commit && (in_idx == out_idx);
   assign irq      = irq_pend && irq_en;

   mq_regs #(
      .DATA_W(DATA_W), .SLOT_W(SLOT_W), .WORD_W(WORD_W),
      .BASE_W(BASE_W), .READ_REG(READ_REG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .in_idx(in_idx), .pend_set(pend_set),
      .reg_rdata(reg_rdata), .start(start), .irq_en(irq_en),
      .irq_pend(irq_pend), .base(base), .out_idx(out_idx),
      .not_full(not_full), .clr_p(clr_p)
   );

   mq_producer #(
      .DATA_W(DATA_W), .SLOT_W(SLOT_W), .WORD_W(WORD_W), .BASE_W(BASE_W)
   ) u_prod (
      .clk(clk), .rst_n(rst_n),
      .prod_req(prod_req), .prod_done(prod_done), .prod_abort(prod_abort),
      .prod_data(prod_data), .start(start), .not_full(not_full),
      .clr_p(clr_p), .base(base), .prod_ack(prod_ack), .ram_we(ram_we),
      .ram_addr(ram_addr), .ram_wdata(ram_wdata), .in_idx(in_idx),
      .commit(commit)
   );
endmodule

// File: rtl/mq_dpram_ctrl_chk.sv
module mq_dpram_ctrl_chk #(
   parameter int SLOT_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              prod_req,
   input logic              prod_ack,
   input logic              ram_we,
   input logic              start,
   input logic              clr_p,
   input logic [SLOT_W-1:0] in_idx,
   input logic [SLOT_W-1:0] out_idx,
   input logic              irq_pend
);
   // R3: write strobe lasts a single cycle
   assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |=> !ram_we);

   // R3: ack held while request stays high
   assert_ack_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (prod_ack && prod_req && !clr_p) |=> prod_ack);

   // R3: ack only falls after request was withdrawn (or clear)
   assert_ack_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prod_ack) |-> (!$past(prod_req) || $past(clr_p)));

   // R6: no write issued from a full queue
   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> $past(SLOT_W'(in_idx + 1'b1) != out_idx));

   // R7: no write issued while not started
   assert_needs_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> $past(start));

   // R4: in index only moves forward by one, except on clear
   assert_in_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(clr_p) && (in_idx != $past(in_idx))) |-> (in_idx == SLOT_W'($past(in_idx) + 1'b1)));

   // R11: pending only raised by a commit into an empty queue
   assert_pend_from_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_pend) |-> ($past(in_idx == out_idx) && (in_idx != out_idx)));
endmodule

bind mq_dpram_ctrl mq_dpram_ctrl_chk #(.SLOT_W(SLOT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .prod_req(prod_req), .prod_ack(prod_ack),
   .ram_we(ram_we), .start(start), .clr_p(clr_p), .in_idx(in_idx),
   .out_idx(out_idx), .irq_pend(irq_pend)
);

// File: tb/tb_mq_dpram_ctrl.sv
module tb_mq_dpram_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        prod_req = 1'b0, prod_done = 1'b0, prod_abort = 1'b0;
   logic [15:0] prod_data = '0;
   logic        prod_ack, ram_we, irq;
   logic [13:0] ram_addr;
   logic [15:0] ram_wdata;
   logic        reg_en = 1'b0, reg_we = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;

   int total = 0;
   int bad = 0;
   int wr_cnt = 0;
   logic [13:0] last_addr = '0;

   logic [3:0] exp_in = 0, exp_out = 0;
   logic [2:0] exp_off = 0;
   logic [6:0] exp_base = 0;
   logic [15:0] v;

   always #10 clk = ~clk;

   mq_dpram_ctrl dut (
      .clk(clk), .rst_n(rst_n), .prod_req(prod_req), .prod_done(prod_done),
      .prod_abort(prod_abort), .prod_data(prod_data), .prod_ack(prod_ack),
      .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   always @(posedge clk) if (ram_we) begin
      wr_cnt    <= wr_cnt + 1;
      last_addr <= ram_addr;
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_en = 0; reg_we = 0;
   endtask

   task automatic reg_rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_en = 1; reg_we = 0; reg_addr = a;
      @(negedge clk);
      reg_en = 0;
      d = reg_rdata;
   endtask

   function automatic logic [15:0] exp_status();
      logic nf, ne;
      nf = (4'(exp_in + 1) != exp_out);
      ne = (exp_in != exp_out);
      return {6'b0, nf, ne, exp_out, exp_in};
   endfunction

   task automatic chk_status(input string tag);
      logic [15:0] r;
      reg_rd(2'd1, r);
      check(tag, r, exp_status());
   endtask

   task automatic send_word(input string tag);
      logic [15:0] d;
      d = {4'hC, exp_in, 1'b0, exp_off, 4'h5};
      @(negedge clk);
      prod_req = 1; prod_data = d;
      @(negedge clk);
      check({tag, " R3 we"}, ram_we, 1);
      check({tag, " R2 addr"}, ram_addr, {exp_base, exp_in, exp_off});
      check({tag, " R3 data"}, ram_wdata, d);
      check({tag, " R3 ack early"}, prod_ack, 0);
      @(negedge clk);
      check({tag, " R3 we one cycle"}, ram_we, 0);
      check({tag, " R3 ack"}, prod_ack, 1);
      @(negedge clk);
      check({tag, " R3 ack held"}, prod_ack, 1);
      prod_req = 0;
      @(negedge clk);
      check({tag, " R3 ack drop"}, prod_ack, 0);
      exp_off++;
   endtask

   task automatic pulse_done();
      @(negedge clk); prod_done = 1;
      @(negedge clk); prod_done = 0;
   endtask

   task automatic pulse_abort();
      @(negedge clk); prod_abort = 1;
      @(negedge clk); prod_abort = 0;
      exp_off = 0;
   endtask

   task automatic commit_msg();
      pulse_done();
      exp_in++; exp_off = 0;
   endtask

   task automatic pop();
      reg_wr(2'd1, 16'h0001);
      if (exp_in != exp_out) exp_out++;
   endtask

   task automatic blocked_req(input string tag);
      int wc;
      wc = wr_cnt;
      @(negedge clk); prod_req = 1;
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         check({tag, " no ack"}, prod_ack, 0);
      end
      check({tag, " no write"}, wr_cnt, wc);
      prod_req = 0;
      @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1 ack", prod_ack, 0);
      check("R1 we", ram_we, 0);
      check("R1 irq", irq, 0);
      chk_status("R1 status");
      reg_rd(2'd0, v);
      check("R1 ctrl", v, 16'h0000);

      // R2 / R12 base register
      exp_base = 7'h5A;
      reg_wr(2'd2, {9'b0, exp_base});
      reg_rd(2'd2, v);
      check("R12 R2 base readback", v, {9'b0, exp_base});

      // R7 not started
      blocked_req("R7 req");
      pulse_done();
      chk_status("R7 done ignored");

      reg_wr(2'd0, 16'h0003);
      send_word("R3 m0w0");
      send_word("R3 m0w1");
      send_word("R3 m0w2");
      commit_msg();
      check("R11 irq on first commit", irq, 1);
      chk_status("R4 R5 after commit");
      reg_rd(2'd3, v);
      check("R9 head", v, {2'b0, exp_base, exp_out, 3'b000});

      reg_wr(2'd0, 16'h000B);
      check("R11 irq ack", irq, 0);

      // R4 abort then fresh message from offset 0
      send_word("R4 ab w0");
      send_word("R4 ab w1");
      pulse_abort();
      chk_status("R4 abort keeps in");
      send_word("R4 after abort w0");
      send_word("R4 after abort w1");
      commit_msg();
      chk_status("R4 commit after abort");
      check("R11 no irq non-empty", irq, 0);

      // R8 pops
      pop(); pop();
      chk_status("R8 popped to empty");
      reg_rd(2'd3, v);
      check("R9 head after pops", v, {2'b0, exp_base, exp_out, 3'b000});
      pop();
      chk_status("R8 empty pop ignored");

      // R5 fill sweep
      for (int k = 0; k < 15; k++) begin
         send_word("R5 fill");
         commit_msg();
         chk_status("R5 fill status");
      end
      check("R5 fifteen held", 32'(4'(exp_in - exp_out)), 15);

      // R6 full
      blocked_req("R6 full req");
      pulse_done();
      chk_status("R6 done ignored when full");
      begin
         int waitc;
         @(negedge clk); prod_req = 1; prod_data = 16'hBEEF;
         repeat (3) @(negedge clk);
         check("R6 held while full", prod_ack, 0);
         reg_en = 1; reg_we = 1; reg_addr = 2'd1; reg_wdata = 16'h0001;
         @(negedge clk);
         reg_en = 0; reg_we = 0;
         exp_out++;
         waitc = 0;
         while (!prod_ack && waitc < 10) begin
            @(negedge clk); waitc++;
         end
         check("R6 served after pop", prod_ack, 1);
         check("R6 R2 addr after pop", last_addr, {exp_base, exp_in, exp_off});
         prod_req = 0;
         @(negedge clk);
         exp_off++;
      end
      commit_msg();
      chk_status("R6 full again");

      // R10 clear (also acks irq)
      reg_wr(2'd0, 16'h000F);
      exp_in = 0; exp_out = 0; exp_off = 0;
      chk_status("R10 clear status");
      reg_rd(2'd0, v);
      check("R10 clr reads 0", v, 16'h0003);

      // R11 gating
      reg_wr(2'd0, 16'h0001);
      send_word("R11 w0");
      commit_msg();
      check("R11 gated off", irq, 0);
      reg_rd(2'd0, v);
      check("R11 pending visible", v, 16'h0009);
      reg_wr(2'd0, 16'h0003);
      check("R11 enable shows irq", irq, 1);
      reg_wr(2'd0, 16'h000B);
      check("R11 ack clears", irq, 0);

      // R2 full offset sweep, new base
      exp_base = 7'h13;
      reg_wr(2'd2, {9'b0, exp_base});
      for (int w = 0; w < 8; w++) send_word("R2 sweep");
      commit_msg();
      chk_status("R2 sweep commit");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule